// File: doc/BRIEF.md
# Two-Window Overlay Hit and Blend

This block sits behind a display timing generator. For every pixel coordinate it is handed, it works out which of two overlay windows cover that coordinate. For each window that covers it, the block pulls one 32-bit word from that window's line source and turns the word into 8-bit red, green and blue. It then composites the result: window 0 is the bottom plane laid over a black background, and window 1 is the top plane laid over window 0. The composite leaves the block as a 24-bit RGB pixel two clocks after the coordinate was presented.

Each window has an enable, an inclusive rectangle given as top-left and bottom-right corners, a format code and a fixed per-channel alpha. Formats that carry alpha blend with the alpha taken from the pixel. Formats without alpha use the fixed per-channel alpha, and a value of 0xFF on a channel makes that channel opaque. Window 1 alone can be colour keyed: if its unpacked colour matches a key value on the bits not masked off, that top pixel becomes fully transparent.

Top module: `ovl_blend`

## Requirements
- R1: While reset is asserted and whenever `out_valid` is low, `out_valid` is 0 and `out_rgb` is 0x000000.
- R2: `out_valid` and `out_rgb` for the coordinate sampled with `in_valid` high at clock edge k appear after clock edge k+2. A new coordinate may be presented every cycle.
- R3: `win_rd[w]` is high in the same cycle as the coordinate only when `in_valid` is high, `win_en[w]` is 1 and tl_x <= x <= br_x and tl_y <= y <= br_y (both bounds inclusive, so tl == br is a one-pixel window). Only then does window w contribute.
- R4: A coordinate that no enabled window covers produces black (0x000000).
- R5: Window 1 is composited over window 0: an opaque window-1 pixel fully replaces the window-0 pixel beneath it.
- R6: Format code 0 is 16-bit 5:6:5 in bits [15:0] (R in [15:11], G in [10:5], B in [4:0]). Each field is widened to 8 bits by repeating its top bits, and bits [31:16] are ignored.
- R7: The opaque 32-bit codes are as follows. Code 1 has pad[31:24], R[23:16], G[15:8], B[7:0]. Code 2 has pad, B, G, R. Code 3 has R[31:24], G[23:16], B[15:8], pad[7:0]. Code 4 has B, G, R, pad.
- R8: The alpha codes are as follows. Code 5 has A[31:24], R, G, B. Code 6 has A, B, G, R. Code 7 has R[31:24], G, B, A[7:0]. Code 8 has B, G, R, A[7:0]. The pixel's A is applied to all three channels.
- R9: Opaque formats use the window's fixed alpha, `win_alpha` = {R alpha[23:16], G alpha[15:8], B alpha[7:0]}.
- R10: When `key_en` is 1 and ((window-1 RGB ^ `key_val`) & ~`key_mask`) == 0, the window-1 pixel is fully transparent (a mask bit of 1 means "don't compare"). Window 0 is never keyed.
- R11: Format codes 9 to 15 are decoded as code 1.
- R12: Each channel is computed as mid = round(a0*c0/255), then out = round((a1*c1 + (255-a1)*mid)/255), where a uncovered window has a = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate valid |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| win_en | input | 2 | Per-window enable |
| win_tl_x | input | 2 x COORD_W | Top-left column per window |
| win_tl_y | input | 2 x COORD_W | Top-left row per window |
| win_br_x | input | 2 x COORD_W | Inclusive bottom-right column per window |
| win_br_y | input | 2 x COORD_W | Inclusive bottom-right row per window |
| win_fmt | input | 2 x 4 | Format code per window |
| win_alpha | input | 2 x 24 | Fixed R/G/B alpha per window for opaque formats |
| win_pix | input | 2 x 32 | Head word of each window's line source |
| win_rd | output | 2 | Consume the head word of that window's source |
| key_en | input | 1 | Colour key enable (window 1) |
| key_val | input | 24 | Colour key value, RGB |
| key_mask | input | 24 | Bits set are excluded from the key compare |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited pixel {R,G,B} |

## Verification
The assertions assume that the window registers, format codes, key settings and line-source words stay steady while a coordinate is being sampled. They also assume that `in_valid` is low during reset, so the two-cycle latency check can trust the first two post-reset edges. The bench changes every configuration input only on the falling clock edge, holds it through the next rising edge, and keeps `in_valid` at 0 until reset has been released. Line-source words are held on the `win_pix` inputs and never change in the middle of a cycle.

// File: rtl/ovl_blend_pkg.sv
package ovl_blend_pkg;
   localparam int NUM_WIN = 2;
   localparam int CH_W    = 8;
   localparam int NUM_CH  = 3;
   localparam int RGB_W   = CH_W * NUM_CH;
   localparam int PIX_W   = 32;
   localparam int FMT_W   = 4;
   localparam int KEY_WIN = 1;

   typedef enum logic [FMT_W-1:0] {
      FMT_RGB565 = 4'd0,
      FMT_XRGB   = 4'd1,
      FMT_XBGR   = 4'd2,
      FMT_RGBX   = 4'd3,
      FMT_BGRX   = 4'd4,
      FMT_ARGB   = 4'd5,
      FMT_ABGR   = 4'd6,
      FMT_RGBA   = 4'd7,
      FMT_BGRA   = 4'd8
   } pix_fmt_e;

   typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/ovl_px_unpack.sv
module ovl_px_unpack
   import ovl_blend_pkg::*;
(
   input  logic [PIX_W-1:0] pix,
   input  logic [FMT_W-1:0] fmt,
   output rgb_t             rgb,
   output logic             has_alpha,
   output logic [CH_W-1:0]  alpha
);
   logic [4:0] r5, b5;
   logic [5:0] g6;

   assign r5 = pix[15:11];
   assign g6 = pix[10:5];
   assign b5 = pix[4:0];

   always_comb begin
      has_alpha = 1'b0;
      alpha     = '0;
      case (fmt)
         FMT_RGB565: rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
         FMT_XBGR:   rgb = {pix[7:0], pix[15:8], pix[23:16]};
         FMT_RGBX:   rgb = pix[31:8];
         FMT_BGRX:   rgb = {pix[15:8], pix[23:16], pix[31:24]};
         FMT_ARGB: begin
            rgb       = pix[23:0];
            has_alpha = 1'b1;
            alpha     = pix[31:24];
         end
         FMT_ABGR: begin
            rgb       = {pix[7:0], pix[15:8], pix[23:16]};
            has_alpha = 1'b1;
            alpha     = pix[31:24];
         end
         FMT_RGBA: begin
            rgb       = pix[31:8];
            has_alpha = 1'b1;
            alpha     = pix[7:0];
         end
         FMT_BGRA: begin
            rgb       = {pix[15:8], pix[23:16], pix[31:24]};
            has_alpha = 1'b1;
            alpha     = pix[7:0];
         end
         default:    rgb = pix[23:0];
      endcase
   end
endmodule

// File: rtl/ovl_win_slice.sv
module ovl_win_slice
   import ovl_blend_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter bit HAS_KEY = 1'b0
) (
   input  logic               in_valid,
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic               en,
   input  logic [COORD_W-1:0] tl_x,
   input  logic [COORD_W-1:0] tl_y,
   input  logic [COORD_W-1:0] br_x,
   input  logic [COORD_W-1:0] br_y,
   input  logic [FMT_W-1:0]   fmt,
   input  rgb_t               fix_alpha,
   input  logic [PIX_W-1:0]   pix,
   input  logic               key_en,
   input  rgb_t               key_val,
   input  rgb_t               key_mask,
   output logic               rd,
   output rgb_t               rgb_o,
   output rgb_t               alpha_o
);
   logic            hit;
   logic            keyed;
   rgb_t            color;
   logic            has_alpha;
   logic [CH_W-1:0] px_alpha;

   assign hit = en && (x >= tl_x) && (x <= br_x) && (y >= tl_y) && (y <= br_y);
   assign rd  = in_valid && hit;

   ovl_px_unpack u_unpack (
      .pix       (pix),
      .fmt       (fmt),
      .rgb       (color),
      .has_alpha (has_alpha),
      .alpha     (px_alpha)
   );

   generate
      if (HAS_KEY) begin : g_key
         assign keyed = key_en && (((color ^ key_val) & ~key_mask) == '0);
      end else begin : g_nokey
         logic unused_key;
         assign unused_key = ^{key_en, key_val, key_mask};
         assign keyed      = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!hit) begin
         rgb_o   = '0;
         alpha_o = '0;
      end else begin
         rgb_o = color;
         if (keyed)
            alpha_o = '0;
         else if (has_alpha)
            alpha_o = {NUM_CH{px_alpha}};
         else
            alpha_o = fix_alpha;
      end
   end
endmodule

// File: rtl/ovl_chan_blend.sv
module ovl_chan_blend #(
   parameter int W = 8
) (
   input  logic [W-1:0] alpha,
   input  logic [W-1:0] top,
   input  logic [W-1:0] bot,
   output logic [W-1:0] mix
);
   localparam int           VW   = 2 * W + 2;
   localparam logic [W-1:0] FULL = '1;
   localparam logic [VW-1:0] HALF = VW'(1) << (W - 1);

   logic [VW-1:0] prod, tmp, fin;
   logic          unused_hi;

   assign prod      = VW'(alpha) * VW'(top) + VW'(FULL - alpha) * VW'(bot);
   assign tmp       = prod + HALF;
   assign fin       = (tmp + (tmp >> W)) >> W;
   assign mix       = fin[W-1:0];
   assign unused_hi = |fin[VW-1:W];
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
   import ovl_blend_pkg::*;
#(
   parameter int COORD_W = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [COORD_W-1:0]              in_x,
   input  logic [COORD_W-1:0]              in_y,
   input  logic [NUM_WIN-1:0]              win_en,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_tl_x,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_tl_y,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_br_x,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_br_y,
   input  logic [NUM_WIN-1:0][FMT_W-1:0]   win_fmt,
   input  logic [NUM_WIN-1:0][RGB_W-1:0]   win_alpha,
   input  logic [NUM_WIN-1:0][PIX_W-1:0]   win_pix,
   output logic [NUM_WIN-1:0]              win_rd,
   input  logic                            key_en,
   input  logic [RGB_W-1:0]                key_val,
   input  logic [RGB_W-1:0]                key_mask,
   output logic                            out_valid,
   output logic [RGB_W-1:0]                out_rgb
);
   initial begin
      if (COORD_W < 2 || COORD_W > 16)
         $error("ovl_blend: COORD_W must lie in 2..16");
      if (NUM_WIN != 2 || KEY_WIN >= NUM_WIN)
         $error("ovl_blend: the compositor expects two windows");
   end

   logic [NUM_WIN-1:0][RGB_W-1:0] sl_rgb, sl_a;
   logic [NUM_WIN-1:0][RGB_W-1:0] s1_rgb, s1_a;
   logic                          s1_valid;
   rgb_t                          mid, mix;

   // per-window hit, fetch and alpha selection
   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         ovl_win_slice #(
            .COORD_W (COORD_W),
            .HAS_KEY (w == KEY_WIN)
         ) u_slice (
            .in_valid  (in_valid),
            .x         (in_x),
            .y         (in_y),
            .en        (win_en[w]),
            .tl_x      (win_tl_x[w]),
            .tl_y      (win_tl_y[w]),
            .br_x      (win_br_x[w]),
            .br_y      (win_br_y[w]),
            .fmt       (win_fmt[w]),
            .fix_alpha (win_alpha[w]),
            .pix       (win_pix[w]),
            .key_en    (key_en),
            .key_val   (key_val),
            .key_mask  (key_mask),
            .rd        (win_rd[w]),
            .rgb_o     (sl_rgb[w]),
            .alpha_o   (sl_a[w])
         );
      end
   endgenerate

   // stage 1: decoded colour and alpha
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_rgb   <= '0;
         s1_a     <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_rgb   <= sl_rgb;
         s1_a     <= sl_a;
      end
   end

   // bottom over black, then top over bottom, per channel
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         ovl_chan_blend #(.W(CH_W)) u_bot (
            .alpha (s1_a[0][c*CH_W +: CH_W]),
            .top   (s1_rgb[0][c*CH_W +: CH_W]),
            .bot   ({CH_W{1'b0}}),
            .mix   (mid[c*CH_W +: CH_W])
         );
         ovl_chan_blend #(.W(CH_W)) u_top (
            .alpha (s1_a[1][c*CH_W +: CH_W]),
            .top   (s1_rgb[1][c*CH_W +: CH_W]),
            .bot   (mid[c*CH_W +: CH_W]),
            .mix   (mix[c*CH_W +: CH_W])
         );
      end
   endgenerate

   // stage 2: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= s1_valid;
         out_rgb   <= s1_valid ? mix : '0;
      end
   end
endmodule

// File: rtl/ovl_blend_chk.sv
module ovl_blend_chk
   import ovl_blend_pkg::*;
#(
   parameter int COORD_W = 12
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            in_valid,
   input logic [COORD_W-1:0]              in_x,
   input logic [COORD_W-1:0]              in_y,
   input logic [NUM_WIN-1:0]              win_en,
   input logic [NUM_WIN-1:0][COORD_W-1:0] win_tl_x,
   input logic [NUM_WIN-1:0][COORD_W-1:0] win_tl_y,
   input logic [NUM_WIN-1:0][COORD_W-1:0] win_br_x,
   input logic [NUM_WIN-1:0][COORD_W-1:0] win_br_y,
   input logic [NUM_WIN-1:0]              win_rd,
   input logic                            out_valid,
   input logic [RGB_W-1:0]                out_rgb
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= 2'd0;
      else if (since_rst != 2'd2)
         since_rst <= since_rst + 2'd1;
   end

   a_r1_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_rgb == '0);

   a_r2_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2) |-> out_valid == $past(in_valid, 2));

   a_r3_win0_fetch_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      win_rd[0] |-> (in_valid && win_en[0] &&
                     in_x >= win_tl_x[0] && in_x <= win_br_x[0] &&
                     in_y >= win_tl_y[0] && in_y <= win_br_y[0]));

   a_r3_win1_fetch_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      win_rd[1] |-> (in_valid && win_en[1] &&
                     in_x >= win_tl_x[1] && in_x <= win_br_x[1] &&
                     in_y >= win_tl_y[1] && in_y <= win_br_y[1]));

   a_r4_uncovered_black: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2 && out_valid && $past(win_rd, 2) == '0) |-> out_rgb == '0);
endmodule

bind ovl_blend ovl_blend_chk #(.COORD_W(COORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_x      (in_x),
   .in_y      (in_y),
   .win_en    (win_en),
   .win_tl_x  (win_tl_x),
   .win_tl_y  (win_tl_y),
   .win_br_x  (win_br_x),
   .win_br_y  (win_br_y),
   .win_rd    (win_rd),
   .out_valid (out_valid),
   .out_rgb   (out_rgb)
);

// File: tb/ovl_blend_bench.sv
`timescale 1ns/1ps
module ovl_blend_bench;
   localparam int CW = 12;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic [CW-1:0]         in_x = '0, in_y = '0;
   logic [1:0]            win_en = 2'b11;
   logic [1:0][CW-1:0]    win_tl_x, win_tl_y, win_br_x, win_br_y;
   logic [1:0][3:0]       win_fmt;
   logic [1:0][23:0]      win_alpha;
   logic [1:0][31:0]      win_pix;
   logic [1:0]            win_rd;
   logic                  key_en = 1'b0;
   logic [23:0]           key_val = 24'h00FF00, key_mask = 24'h0F0F0F;
   logic                  out_valid;
   logic [23:0]           out_rgb;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ovl_blend #(.COORD_W(CW)) u_ovl_blend (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
      .win_en(win_en), .win_tl_x(win_tl_x), .win_tl_y(win_tl_y),
      .win_br_x(win_br_x), .win_br_y(win_br_y), .win_fmt(win_fmt),
      .win_alpha(win_alpha), .win_pix(win_pix), .win_rd(win_rd),
      .key_en(key_en), .key_val(key_val), .key_mask(key_mask),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   typedef struct packed {
      logic [CW-1:0] x;
      logic [CW-1:0] y;
      logic [3:0]    f0;
      logic [31:0]   p0;
      logic [3:0]    f1;
      logic [31:0]   p1;
      logic          k;
      logic [1:0]    rd;
      logic [23:0]   rgb;
   } vec_t;

   // window 0: (10,10)-(49,29); window 1: (20,15)-(27,22); key 00FF00, mask 0F0F0F
   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{12'd5,  12'd5,  4'd1, 32'h00FFFFFF, 4'd1,  32'h00FFFFFF, 1'b0, 2'b00, 24'h000000}, // R4
      '{12'd10, 12'd10, 4'd1, 32'h00123456, 4'd1,  32'h00000000, 1'b0, 2'b01, 24'h123456}, // R3
      '{12'd49, 12'd29, 4'd2, 32'h00123456, 4'd1,  32'h00000000, 1'b0, 2'b01, 24'h563412}, // R7
      '{12'd50, 12'd29, 4'd1, 32'h00123456, 4'd1,  32'h00000000, 1'b0, 2'b00, 24'h000000}, // R3
      '{12'd20, 12'd15, 4'd1, 32'h00123456, 4'd1,  32'h00ABCDEF, 1'b0, 2'b11, 24'hABCDEF}, // R5
      '{12'd27, 12'd22, 4'd1, 32'h00123456, 4'd3,  32'h11223344, 1'b0, 2'b11, 24'h112233}, // R7
      '{12'd21, 12'd16, 4'd1, 32'h00123456, 4'd4,  32'h11223344, 1'b0, 2'b11, 24'h332211}, // R7
      '{12'd25, 12'd20, 4'd1, 32'h00123456, 4'd0,  32'h0000F81F, 1'b0, 2'b11, 24'hFF00FF}, // R6
      '{12'd25, 12'd21, 4'd1, 32'h00123456, 4'd0,  32'hFFFF8410, 1'b0, 2'b11, 24'h848284}, // R6
      '{12'd22, 12'd18, 4'd1, 32'h000000FF, 4'd5,  32'h80FF0000, 1'b0, 2'b11, 24'h80007F}, // R8 R12
      '{12'd22, 12'd19, 4'd1, 32'h000000FF, 4'd6,  32'h00FF0000, 1'b0, 2'b11, 24'h0000FF}, // R8
      '{12'd23, 12'd18, 4'd1, 32'h00123456, 4'd7,  32'h00FF00FF, 1'b0, 2'b11, 24'h00FF00}, // R8
      '{12'd23, 12'd19, 4'd1, 32'h00000000, 4'd8,  32'hFF000040, 1'b0, 2'b11, 24'h000040}, // R8
      '{12'd24, 12'd18, 4'd1, 32'h00123456, 4'd12, 32'h00654321, 1'b0, 2'b11, 24'h654321}, // R11
      '{12'd24, 12'd19, 4'd1, 32'h00123456, 4'd1,  32'h0003FF05, 1'b1, 2'b11, 24'h123456}, // R10
      '{12'd24, 12'd20, 4'd1, 32'h00123456, 4'd1,  32'h0010FF00, 1'b1, 2'b11, 24'h10FF00}, // R10
      '{12'd12, 12'd12, 4'd1, 32'h0000FF00, 4'd1,  32'h0000FF00, 1'b1, 2'b01, 24'h00FF00}  // R10
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v, input string req);
      @(negedge clk);
      in_x = v.x; in_y = v.y;
      win_fmt[0] = v.f0; win_pix[0] = v.p0;
      win_fmt[1] = v.f1; win_pix[1] = v.p1;
      key_en = v.k; in_valid = 1'b1;
      #1 check({req, " fetch"}, 32'(win_rd), 32'(v.rd));
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check({req, " valid"}, 32'(out_valid), 32'd1);
      check({req, " pixel"}, 32'(out_rgb), 32'(v.rgb));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      win_tl_x[0] = 12'd10; win_tl_y[0] = 12'd10; win_br_x[0] = 12'd49; win_br_y[0] = 12'd29;
      win_tl_x[1] = 12'd20; win_tl_y[1] = 12'd15; win_br_x[1] = 12'd27; win_br_y[1] = 12'd22;
      win_fmt = '0; win_pix = '0;
      win_alpha[0] = 24'hFFFFFF; win_alpha[1] = 24'hFFFFFF;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset valid", 32'(out_valid), 32'd0);
      check("R1 reset pixel", 32'(out_rgb), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle valid", 32'(out_valid), 32'd0);
      check("R3 no fetch without valid", 32'(win_rd), 32'd0);

      for (int i = 0; i < NV; i++) apply(VECS[i], $sformatf("table[%0d]", i));

      // R3: disabled window takes no part
      win_en = 2'b01;
      apply('{12'd20, 12'd15, 4'd1, 32'h00123456, 4'd1, 32'h00FFFFFF, 1'b0, 2'b01, 24'h123456}, "R3 disabled");
      win_en = 2'b11;

      // R3: one-pixel window, tl == br
      win_tl_x[1] = 12'd30; win_br_x[1] = 12'd30; win_tl_y[1] = 12'd25; win_br_y[1] = 12'd25;
      apply('{12'd30, 12'd25, 4'd1, 32'h00123456, 4'd1, 32'h00ABCDEF, 1'b0, 2'b11, 24'hABCDEF}, "R3 single in");
      apply('{12'd31, 12'd25, 4'd1, 32'h00123456, 4'd1, 32'h00ABCDEF, 1'b0, 2'b01, 24'h123456}, "R3 single out");
      win_tl_x[1] = 12'd20; win_br_x[1] = 12'd27; win_tl_y[1] = 12'd15; win_br_y[1] = 12'd22;

      // R9 R12: fixed per-channel alpha on opaque formats
      win_alpha[1] = 24'h8000FF;
      apply('{12'd20, 12'd15, 4'd1, 32'h00000000, 4'd1, 32'h00FFFFFF, 1'b0, 2'b11, 24'h8000FF}, "R9 top fixed");
      win_alpha[1] = 24'hFFFFFF; win_alpha[0] = 24'h404040;
      apply('{12'd11, 12'd11, 4'd1, 32'h00FFFFFF, 4'd1, 32'h00000000, 1'b0, 2'b01, 24'h404040}, "R9 bottom fixed");
      win_alpha[0] = 24'hFFFFFF;

      // R2: back-to-back stream, two-cycle latency
      win_fmt = '0; win_fmt[0] = 4'd1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2 && i < 5) begin
            check("R2 stream valid", 32'(out_valid), 32'd1);
            check("R2 stream pixel", 32'(out_rgb), 32'(24'h000011 * (i - 1)));
         end else if (i == 5) begin
            check("R2 stream end", 32'(out_valid), 32'd0);
            check("R1 quiet pixel", 32'(out_rgb), 32'd0);
         end
         if (i < 3) begin
            in_valid = 1'b1; in_x = 12'(11 + i); in_y = 12'd11;
            win_pix[0] = 32'(24'h000011 * (i + 1));
         end else begin
            in_valid = 1'b0;
         end
      end

      finish_run();
   end
endmodule